// File: doc/BRIEF.md
# Receive Frame Ring Buffer

This block stores incoming Ethernet frames in a ring of equal-size frame slots and hands them to a host one 32-bit word at a time. Frames arrive as a byte stream with `in_valid`, `in_start` and `in_last` strobes and an `in_ready` back-pressure output. The payload is written into the chosen slot as it arrives. A CRC-32 is worked out one byte per cycle alongside it. After the last byte, the block appends the CRC and zero padding and then writes a two-byte length header at the front of the slot. Only then is the frame counted.

The host pops words with `rd_en`. When a frame's final word has been read, the block moves to the next slot on its own. `pkt_count` reports how many frames are stored. A one-cycle `rx_done` marks each committed frame, and a one-cycle `rx_ovf` marks a frame discarded for being too long. `rx_en` gates acceptance of new frames. `fifo_clr` empties the buffer and abandons any frame that is still arriving.

Top module: `rx_frame_ring`

## Requirements
- R1: After reset, `pkt_count` is 0, `in_ready` is 1, `rd_data` is 0, and `rx_done` and `rx_ovf` are low.
- R2: A stored frame with payload length L is laid out in its slot as follows: byte 0 holds the low byte of L+6 and byte 1 holds the high byte; bytes 2..L+1 hold the payload in arrival order; the four CRC bytes follow, least significant first; zero bytes then pad the record to a multiple of 4. Each word read places slot byte 4w+k in `rd_data` bits [8k+7:8k].
- R3: The CRC is the reflected CRC-32 (polynomial 0xEDB88320) over the payload bytes only. It starts from all ones and is complemented at the end, so the payload "123456789" gives 0xCBF43926.
- R4: Let pad = (2 - L) mod 4. Counting from the clock edge that accepts the last byte, `rx_done` is high for exactly one cycle after edge 4+pad, and `pkt_count` rises by one at edge 5+pad. The count does not change before then.
- R5: Each `rd_en` while `pkt_count` is non-zero loads the next word at that clock edge. The read that reaches or passes the stored length L+6 decrements `pkt_count` at the same edge, and the next read starts the following frame. Frames come out in arrival order across the wrap of the slot index.
- R6: A read while `pkt_count` is 0 loads 0 into `rd_data` and changes no count.
- R7: When `pkt_count` equals the number of slots and no frame is in progress, `in_ready` is low and offered bytes are not consumed. One completed frame read brings `in_ready` back high.
- R8: A frame whose payload reaches SLOT_BYTES-6 bytes is discarded. `rx_ovf` pulses exactly once, in the cycle after the edge that accepts the byte which reaches the limit. No `rx_done` follows and `pkt_count` is unchanged. Bytes after that point up to `in_last` are consumed.
- R9: A frame that starts while `rx_en` is low is consumed and discarded, with no `rx_done` and no count change.
- R10: `fifo_clr` sets `pkt_count` and the read offset to 0 at the next edge. A frame in progress at that time is discarded through to its `in_last`, and the next stored frame reads from its first word.
- R11: When a commit and a frame-completing read fall on the same edge, `pkt_count` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Accept new frames when high |
| fifo_clr | input | 1 | Empty the buffer and abandon a frame in progress |
| in_valid | input | 1 | Input byte valid |
| in_start | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Input payload byte |
| in_ready | output | 1 | Block can consume a byte |
| rd_en | input | 1 | Pop one word |
| rd_data | output | 32 | Word loaded by the last read |
| pkt_count | output | $clog2(NSLOTS+1) | Stored frame count |
| rx_done | output | 1 | One-cycle pulse when a frame commits |
| rx_ovf | output | 1 | One-cycle pulse when an oversize frame is discarded |

## Verification
`rd_data` and the frame count respond at the same edge that samples `rd_en`. A commit takes 5+pad edges after the last byte, and `rx_done` is visible during the cycle before the count moves. `rx_ovf` appears one cycle after the byte that reaches the limit. The bench drives every input just after a falling edge and samples just after the next one, so each result is read exactly one edge after its cause. Commits are checked at the precise cycle that (2 - L) mod 4 predicts, over every legal payload length. Word contents, CRC and padding are rebuilt arithmetically in the bench. The CRC is computed with an MSB-first, bit-reversed formulation that differs from the design's.

// File: rtl/rxfr_pkg.sv
package rxfr_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    ING_IDLE,
    ING_RECV,
    ING_DROP,
    ING_TAIL,
    ING_DONE
  } ing_state_e;

  // One byte of the reflected CRC-32, low bit first.
  function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r >> 1) ^ (((r[0] ^ b[i]) != 1'b0) ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction

  // Zero bytes needed after header + payload + CRC to reach a word boundary.
  function automatic logic [1:0] pad_of(logic [1:0] len_lo);
    return 2'd2 - len_lo;
  endfunction

endpackage

// File: rtl/rxfr_crc32.sv
module rxfr_crc32
  import rxfr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        step,
  input  logic [7:0]  din,
  output logic [31:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= CRC_SEED;
    end else if (load) begin
      crc <= crc32_step(CRC_SEED, din);
    end else if (step) begin
      crc <= crc32_step(crc, din);
    end
  end

endmodule

// File: rtl/rxfr_ingest.sv
module rxfr_ingest
  import rxfr_pkg::*;
#(
  parameter int SLOT_BYTES = 64,
  parameter int SW = 5,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rx_en,
  input  logic          full,
  input  logic [SW-1:0] free_slot,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic          in_last,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          bw_en,
  output logic [SW-1:0] bw_slot,
  output logic [AW-1:0] bw_addr,
  output logic [7:0]    bw_data,
  output logic          commit,
  output logic [AW:0]   commit_len,
  output logic          ovf,
  output logic          idle
);

  localparam logic [AW:0] LIMV = (AW+1)'(SLOT_BYTES - 6);

  ing_state_e    st_q;
  logic [AW-1:0] len_q;
  logic [2:0]    tcnt_q;
  logic [SW-1:0] slot_q;
  logic          ovf_q;
  logic [31:0]   crc_q;
  logic [31:0]   crc_fin;
  logic [1:0]    pad;
  logic          accept, take_first, take_byte, limit_hit, tail_last, mid_frame;
  logic [7:0]    tail_byte;

  assign accept     = in_valid && in_ready;
  assign take_first = (st_q == ING_IDLE) && accept && in_start && rx_en;
  assign limit_hit  = ({1'b0, len_q} + (AW+1)'(1)) >= LIMV;
  assign take_byte  = (st_q == ING_RECV) && accept && !limit_hit;
  assign pad        = pad_of(len_q[1:0]);
  assign tail_last  = (tcnt_q == (3'd3 + {1'b0, pad}));
  assign crc_fin    = ~crc_q;
  assign mid_frame  = ((st_q == ING_RECV) || (st_q == ING_DROP) ||
                       ((st_q == ING_IDLE) && accept && in_start)) &&
                      !(accept && in_last);

  rxfr_crc32 u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .load (take_first),
    .step (take_byte),
    .din  (in_data),
    .crc  (crc_q)
  );

  always_comb begin
    case (tcnt_q)
      3'd0:    tail_byte = crc_fin[7:0];
      3'd1:    tail_byte = crc_fin[15:8];
      3'd2:    tail_byte = crc_fin[23:16];
      3'd3:    tail_byte = crc_fin[31:24];
      default: tail_byte = 8'h00;
    endcase
  end

  always_comb begin
    bw_en   = 1'b0;
    bw_addr = AW'(2) + len_q;
    bw_data = in_data;
    if (take_first) begin
      bw_en   = 1'b1;
      bw_addr = AW'(2);
    end else if (take_byte) begin
      bw_en   = 1'b1;
    end else if (st_q == ING_TAIL) begin
      bw_en   = 1'b1;
      bw_addr = AW'(2) + len_q + AW'(tcnt_q);
      bw_data = tail_byte;
    end
  end

  always_comb begin
    case (st_q)
      ING_IDLE: in_ready = !full;
      ING_RECV: in_ready = 1'b1;
      ING_DROP: in_ready = 1'b1;
      default:  in_ready = 1'b0;
    endcase
  end

  assign bw_slot    = take_first ? free_slot : slot_q;
  assign commit     = (st_q == ING_DONE) && !clr;
  assign commit_len = {1'b0, len_q} + (AW+1)'(6);
  assign ovf        = ovf_q;
  assign idle       = (st_q == ING_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ING_IDLE;
      len_q  <= '0;
      tcnt_q <= '0;
      slot_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      ovf_q <= (st_q == ING_RECV) && accept && limit_hit && !clr;
      if (clr) begin
        st_q <= mid_frame ? ING_DROP : ING_IDLE;
      end else begin
        case (st_q)
          ING_IDLE: begin
            if (accept && in_start) begin
              if (rx_en) begin
                slot_q <= free_slot;
                len_q  <= AW'(1);
                tcnt_q <= '0;
                st_q   <= in_last ? ING_TAIL : ING_RECV;
              end else if (!in_last) begin
                st_q <= ING_DROP;
              end
            end
          end
          ING_RECV: begin
            if (accept) begin
              if (limit_hit) begin
                st_q <= in_last ? ING_IDLE : ING_DROP;
              end else begin
                len_q <= len_q + AW'(1);
                if (in_last) begin
                  tcnt_q <= '0;
                  st_q   <= ING_TAIL;
                end
              end
            end
          end
          ING_DROP: begin
            if (accept && in_last) st_q <= ING_IDLE;
          end
          ING_TAIL: begin
            if (tail_last) st_q <= ING_DONE;
            else           tcnt_q <= tcnt_q + 3'd1;
          end
          default: st_q <= ING_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rxfr_store.sv
module rxfr_store #(
  parameter int NSLOTS = 31,
  parameter int SLOT_BYTES = 64,
  parameter int SW = 5,
  parameter int AW = 6,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bw_en,
  input  logic [SW-1:0] bw_slot,
  input  logic [AW-1:0] bw_addr,
  input  logic [7:0]    bw_data,
  input  logic          commit,
  input  logic [AW:0]   commit_len,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  output logic [CW-1:0] count,
  output logic [SW-1:0] free_slot,
  output logic          full,
  output logic          frame_pop
);

  localparam int MEMSZ = NSLOTS * SLOT_BYTES;
  localparam int MW = $clog2(MEMSZ);

  logic [7:0]    mem  [MEMSZ];
  logic [AW:0]   slen [NSLOTS];
  logic [SW-1:0] head_q;
  logic [CW-1:0] count_q;
  logic [AW-1:0] off_q;
  logic [31:0]   rd_word;
  logic [15:0]   hdr16;
  logic [SW:0]   slot_sum;
  logic          rd_acc, last_word;

  function automatic logic [MW-1:0] bidx(logic [SW-1:0] s, logic [AW-1:0] a);
    return MW'(s) * MW'(SLOT_BYTES) + MW'(a);
  endfunction

  assign rd_acc    = rd_en && !clr && (count_q != '0);
  assign last_word = ({1'b0, off_q} + (AW+1)'(4)) >= slen[head_q];
  assign frame_pop = rd_acc && last_word;
  assign hdr16     = 16'(commit_len);
  assign slot_sum  = (SW+1)'(head_q) + (SW+1)'(count_q);
  assign free_slot = (slot_sum >= (SW+1)'(NSLOTS)) ? SW'(slot_sum - (SW+1)'(NSLOTS))
                                                    : SW'(slot_sum);
  assign full      = (count_q == CW'(NSLOTS));
  assign count     = count_q;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      rd_word[8*k +: 8] = mem[bidx(head_q, {off_q[AW-1:2], 2'(k)})];
    end
  end

  always_ff @(posedge clk) begin
    if (bw_en) mem[bidx(bw_slot, bw_addr)] <= bw_data;
    if (commit) begin
      mem[bidx(bw_slot, AW'(0))] <= hdr16[7:0];
      mem[bidx(bw_slot, AW'(1))] <= hdr16[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOTS; i++) slen[i] <= '0;
    end else if (commit) begin
      slen[bw_slot] <= commit_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
      off_q   <= '0;
      rd_data <= '0;
    end else if (clr) begin
      count_q <= '0;
      off_q   <= '0;
      rd_data <= '0;
    end else begin
      if (rd_en) rd_data <= rd_acc ? rd_word : 32'h0;
      if (rd_acc) begin
        if (last_word) begin
          off_q  <= '0;
          head_q <= (head_q == SW'(NSLOTS - 1)) ? '0 : head_q + SW'(1);
        end else begin
          off_q <= off_q + AW'(4);
        end
      end
      count_q <= count_q + CW'(commit) - CW'(frame_pop);
    end
  end

endmodule

// File: rtl/rx_frame_ring.sv
module rx_frame_ring #(
  parameter int NSLOTS = 31,
  parameter int SLOT_BYTES = 64,
  localparam int SW = $clog2(NSLOTS),
  localparam int AW = $clog2(SLOT_BYTES),
  localparam int CW = $clog2(NSLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          fifo_clr,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic          in_last,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  output logic [CW-1:0] pkt_count,
  output logic          rx_done,
  output logic          rx_ovf
);

  logic          full;
  logic [SW-1:0] free_slot;
  logic          bw_en;
  logic [SW-1:0] bw_slot;
  logic [AW-1:0] bw_addr;
  logic [7:0]    bw_data;
  logic          commit;
  logic [AW:0]   commit_len;
  logic          ing_idle;
  logic          frame_pop;

  rxfr_ingest #(
    .SLOT_BYTES(SLOT_BYTES),
    .SW(SW),
    .AW(AW)
  ) u_ingest (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .rx_en     (rx_en),
    .full      (full),
    .free_slot (free_slot),
    .in_valid  (in_valid),
    .in_start  (in_start),
    .in_last   (in_last),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .bw_en     (bw_en),
    .bw_slot   (bw_slot),
    .bw_addr   (bw_addr),
    .bw_data   (bw_data),
    .commit    (commit),
    .commit_len(commit_len),
    .ovf       (rx_ovf),
    .idle      (ing_idle)
  );

  rxfr_store #(
    .NSLOTS(NSLOTS),
    .SLOT_BYTES(SLOT_BYTES),
    .SW(SW),
    .AW(AW),
    .CW(CW)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .bw_en     (bw_en),
    .bw_slot   (bw_slot),
    .bw_addr   (bw_addr),
    .bw_data   (bw_data),
    .commit    (commit),
    .commit_len(commit_len),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .count     (pkt_count),
    .free_slot (free_slot),
    .full      (full),
    .frame_pop (frame_pop)
  );

  assign rx_done = commit;

endmodule

// File: rtl/rxfr_checker.sv
module rxfr_checker #(
  parameter int NSLOTS = 31,
  localparam int CW = $clog2(NSLOTS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_clr,
  input logic          rd_en,
  input logic          in_ready,
  input logic [31:0]   rd_data,
  input logic [CW-1:0] pkt_count,
  input logic          rx_done,
  input logic          rx_ovf,
  input logic          ing_idle,
  input logic          frame_pop
);

  a_r4_commit_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !frame_pop) |=> (pkt_count == $past(pkt_count) + CW'(1)));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  a_r11_pop_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && frame_pop) |=> (pkt_count == $past(pkt_count)));

  a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && pkt_count == '0 && !rx_done && !fifo_clr) |=> (rd_data == 32'h0 && pkt_count == '0));

  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (pkt_count == '0));

  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ing_idle && pkt_count == CW'(NSLOTS)) |-> !in_ready);

  a_r8_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> !rx_ovf);

  a_r8_ovf_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |-> !rx_done);

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_count <= CW'(NSLOTS));

endmodule

bind rx_frame_ring rxfr_checker #(.NSLOTS(NSLOTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fifo_clr (fifo_clr),
  .rd_en    (rd_en),
  .in_ready (in_ready),
  .rd_data  (rd_data),
  .pkt_count(pkt_count),
  .rx_done  (rx_done),
  .rx_ovf   (rx_ovf),
  .ing_idle (ing_idle),
  .frame_pop(frame_pop)
);

// File: tb/rx_frame_ring_test.sv
module rx_frame_ring_test;

  localparam int NS  = 4;
  localparam int SB  = 32;
  localparam int LIM = SB - 6;
  localparam int CW  = $clog2(NS + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b1;
  logic          fifo_clr = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_start = 1'b0;
  logic          in_last = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready;
  logic          rd_en = 1'b0;
  logic [31:0]   rd_data;
  logic [CW-1:0] pkt_count;
  logic          rx_done;
  logic          rx_ovf;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  rx_frame_ring #(.NSLOTS(NS), .SLOT_BYTES(SB)) uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fifo_clr(fifo_clr),
    .in_valid(in_valid), .in_start(in_start), .in_last(in_last), .in_data(in_data),
    .in_ready(in_ready), .rd_en(rd_en), .rd_data(rd_data), .pkt_count(pkt_count),
    .rx_done(rx_done), .rx_ovf(rx_ovf)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int i);
    if (seed == 0) return 8'(8'h31 + i);
    return 8'((seed * 37 + i * 13 + 5) & 255);
  endfunction

  // MSB-first normal-form CRC on bit-reversed input, result reversed back.
  function automatic logic [31:0] crc_ref(int len, int seed);
    logic [31:0] c;
    logic [31:0] r;
    logic [7:0]  b;
    logic        fb;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      b = pat(seed, i);
      for (int j = 0; j < 8; j++) begin
        fb = c[31] ^ b[j];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    for (int j = 0; j < 32; j++) r[j] = c[31-j];
    return ~r;
  endfunction

  function automatic logic [7:0] rec_byte(int len, int seed, int k);
    logic [31:0] c;
    int tot;
    tot = len + 6;
    c = crc_ref(len, seed);
    if (k == 0) return 8'(tot & 255);
    if (k == 1) return 8'((tot >> 8) & 255);
    if (k < 2 + len) return pat(seed, k - 2);
    if (k < 6 + len) return 8'(c >> (8 * (k - 2 - len)));
    return 8'h00;
  endfunction

  function automatic logic [31:0] rec_word(int len, int seed, int w);
    return {rec_byte(len, seed, 4*w+3), rec_byte(len, seed, 4*w+2),
            rec_byte(len, seed, 4*w+1), rec_byte(len, seed, 4*w)};
  endfunction

  function automatic int nwords(int len);
    return (len + 6 + 3) / 4;
  endfunction

  // Drives a frame one byte per cycle; leaves inputs idle just after the last-byte edge.
  task automatic drive(input int len, input int seed,
                       output int ovf_at, output int ovf_n, output int done_n);
    ovf_at = -1; ovf_n = 0; done_n = 0;
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      if (rx_ovf) begin
        ovf_n++;
        if (ovf_at < 0) ovf_at = i - 1;
      end
      if (rx_done) done_n++;
      if (i < len) begin
        in_valid = 1'b1; in_start = (i == 0); in_last = (i == len - 1);
        in_data = pat(seed, i);
      end else begin
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
      end
    end
  endtask

  task automatic watch(input int n, inout int ovf_n, inout int done_n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rx_ovf) ovf_n++;
      if (rx_done) done_n++;
    end
  endtask

  task automatic send_good(input int len, input int seed, input bit pop_last,
                           input logic [31:0] pop_exp);
    int old, ovf_at, ovf_n, done_n, pad;
    old = int'(pkt_count);
    drive(len, seed, ovf_at, ovf_n, done_n);
    chk(done_n == 0 && ovf_n == 0, "R4", "no early pulse", 32'(done_n + ovf_n), 0);
    pad = (2 - len) & 3;
    repeat (4 + pad) @(negedge clk);
    chk(rx_done == 1'b1, "R4", "rx_done at 4+pad", 32'(rx_done), 1);
    chk(int'(pkt_count) == old, "R4", "count before commit", 32'(pkt_count), 32'(old));
    if (pop_last) rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (pop_last) begin
      chk(rd_data == pop_exp, "R11", "word popped at commit", rd_data, pop_exp);
      chk(int'(pkt_count) == old, "R11", "count with pop and commit", 32'(pkt_count), 32'(old));
    end else begin
      chk(int'(pkt_count) == old + 1, "R4", "count after commit", 32'(pkt_count), 32'(old + 1));
    end
    chk(rx_done == 1'b0, "R4", "rx_done one cycle", 32'(rx_done), 0);
  endtask

  task automatic read_words(input int len, input int seed, input int w0, input int w1);
    int old;
    logic [31:0] exp;
    for (int w = w0; w < w1; w++) begin
      @(negedge clk);
      old = int'(pkt_count);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      exp = rec_word(len, seed, w);
      chk(rd_data == exp, "R2", "record word", rd_data, exp);
      if (w == nwords(len) - 1)
        chk(int'(pkt_count) == old - 1, "R5", "count after last word", 32'(pkt_count), 32'(old - 1));
      else
        chk(int'(pkt_count) == old, "R5", "count mid frame", 32'(pkt_count), 32'(old));
    end
  endtask

  task automatic empty_read();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == 32'h0, "R6", "empty read data", rd_data, 0);
    chk(pkt_count == '0, "R6", "empty read count", 32'(pkt_count), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int ovf_at, ovf_n, done_n;
    logic [7:0]  bytes [16];
    logic [31:0] crcw;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pkt_count == '0, "R1", "reset count", 32'(pkt_count), 0);
    chk(in_ready == 1'b1, "R1", "reset ready", 32'(in_ready), 1);
    chk(rd_data == 32'h0, "R1", "reset rd_data", rd_data, 0);
    chk(rx_done == 1'b0 && rx_ovf == 1'b0, "R1", "reset pulses", 32'({rx_done, rx_ovf}), 0);

    empty_read();

    // R3: known check value over "123456789"
    send_good(9, 0, 1'b0, 32'h0);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      for (int k = 0; k < 4; k++) bytes[4*w+k] = rd_data[8*k +: 8];
    end
    crcw = {bytes[14], bytes[13], bytes[12], bytes[11]};
    chk(crcw == 32'hCBF43926, "R3", "crc check value", crcw, 32'hCBF43926);
    chk(pkt_count == '0, "R5", "count after crc frame", 32'(pkt_count), 0);

    // R2 R3 R4 R5: every legal payload length, slot index wraps repeatedly
    for (int len = 1; len < LIM; len++) begin
      send_good(len, len, 1'b0, 32'h0);
      read_words(len, len, 0, nwords(len));
    end
    empty_read();

    // R7: fill every slot, then offer a frame
    send_good(5, 40, 1'b0, 32'h0);
    send_good(10, 41, 1'b0, 32'h0);
    send_good(17, 42, 1'b0, 32'h0);
    send_good(22, 43, 1'b0, 32'h0);
    chk(int'(pkt_count) == NS, "R7", "count when full", 32'(pkt_count), 32'(NS));
    chk(in_ready == 1'b0, "R7", "ready low when full", 32'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b1; in_start = 1'b1; in_last = 1'b1; in_data = 8'hAA;
    done_n = 0; ovf_n = 0;
    watch(6, ovf_n, done_n);
    chk(in_ready == 1'b0 && done_n == 0, "R7", "byte held off", 32'(done_n), 0);
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
    read_words(5, 40, 0, nwords(5));
    chk(in_ready == 1'b1, "R7", "ready after a read", 32'(in_ready), 1);
    read_words(10, 41, 0, nwords(10));
    read_words(17, 42, 0, nwords(17));
    read_words(22, 43, 0, nwords(22));

    // R8: oversize frames, at the limit and past it
    for (int t = 0; t < 2; t++) begin
      int len;
      len = (t == 0) ? LIM : LIM + 4;
      drive(len, 50 + t, ovf_at, ovf_n, done_n);
      watch(12, ovf_n, done_n);
      chk(ovf_at == LIM - 1, "R8", "ovf cycle", 32'(ovf_at), 32'(LIM - 1));
      chk(ovf_n == 1, "R8", "single ovf pulse", 32'(ovf_n), 1);
      chk(done_n == 0 && pkt_count == '0, "R8", "oversize not stored", 32'(pkt_count), 0);
    end

    // R9: receive disabled
    rx_en = 1'b0;
    drive(8, 55, ovf_at, ovf_n, done_n);
    watch(12, ovf_n, done_n);
    chk(done_n == 0 && pkt_count == '0, "R9", "disabled frame dropped", 32'(done_n), 0);
    rx_en = 1'b1;
    send_good(7, 56, 1'b0, 32'h0);
    read_words(7, 56, 0, nwords(7));

    // R10: clear with a partly read frame
    send_good(6, 60, 1'b0, 32'h0);
    send_good(11, 61, 1'b0, 32'h0);
    read_words(6, 60, 0, 1);
    @(negedge clk); fifo_clr = 1'b1;
    @(negedge clk); fifo_clr = 1'b0;
    chk(pkt_count == '0, "R10", "count cleared", 32'(pkt_count), 0);
    empty_read();
    send_good(9, 62, 1'b0, 32'h0);
    read_words(9, 62, 0, nwords(9));

    // R10: clear during an arriving frame
    done_n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rx_done) done_n++;
      in_valid = 1'b1; in_start = (i == 0); in_last = (i == 9);
      in_data = pat(63, i);
      fifo_clr = (i == 4);
    end
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; fifo_clr = 1'b0;
    ovf_n = 0;
    watch(12, ovf_n, done_n);
    chk(done_n == 0 && pkt_count == '0, "R10", "aborted frame dropped", 32'(pkt_count), 0);
    send_good(4, 64, 1'b0, 32'h0);
    read_words(4, 64, 0, nwords(4));

    // R11: final read of one frame on the commit edge of the next
    send_good(3, 70, 1'b0, 32'h0);
    read_words(3, 70, 0, 2);
    send_good(5, 71, 1'b1, rec_word(3, 70, 2));
    chk(int'(pkt_count) == 1, "R11", "one frame left", 32'(pkt_count), 1);
    read_words(5, 71, 0, nwords(5));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule